// File: doc/BRIEF.md
# Display Timing Generator

This block produces the line sync, frame sync, data-enable strobe and active-area pixel coordinates for a parallel RGB panel. It emits one pixel per clock. Each axis runs through the same phases in a fixed order: a reference interval, the sync pulse, the back porch, the active period and then the front porch. The horizontal axis counts pixel clocks. The vertical axis counts whole lines and advances once at the end of every line.

Five 32-bit configuration words program the block. Four of them hold the phase lengths and one holds the active size. In every word the horizontal value sits in bits 15:0 and the vertical value in bits 31:16. The usual setting for the reference interval is 1 on both axes. Software then programs the front porch as the panel's front margin minus one, so the line and frame totals still match the panel. The words are sampled only at frame boundaries, so a rewrite in the middle of a frame never tears the picture. Two polarity inputs invert line sync and frame sync on their own.

Top module: `dtg_timing`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, data enable is 0, both coordinates are 0, and each sync output sits at its inactive level (the value of its inversion input). Counting starts at line position 0 of line 0 on the following cycle.
- R2: A line lasts `ref + sync + back + width + front` clocks, taking the low halves of the words. A frame lasts the same sum of the high halves, counted in lines.
- R3: Before inversion, line sync is high for clock positions p in the line with `ref_h <= p < ref_h + sync_h`.
- R4: Before inversion, frame sync is high for every clock of lines l with `ref_v <= l < ref_v + sync_v`. It only changes at a line boundary.
- R5: Data enable is high only when the line position is inside `[ref_h+sync_h+back_h, +width)` and the line number is inside `[ref_v+sync_v+back_v, +height)`.
- R6: While data enable is high, x_o and y_o give the offset of the current pixel from the first active column and the first active line. Both are 0 whenever data enable is low.
- R7: The configuration words are captured in the first cycle after reset and in the last cycle of each frame. A change at any other time has no effect until the next frame starts.
- R8: Bits 15:0 of each word configure the horizontal axis and bits 31:16 configure the vertical axis.
- R9: hs_inv_i = 1 inverts hsync_o and vs_inv_i = 1 inverts vsync_o. Both take effect in the same cycle and act independently.
- R10: A phase length of 0 (back or front porch) removes that phase without disturbing the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_sync_i | input | 32 | Reference-to-sync length, {vertical, horizontal} |
| sync_width_i | input | 32 | Sync pulse length, {vertical, horizontal} |
| back_porch_i | input | 32 | Back porch length, {vertical, horizontal} |
| front_porch_i | input | 32 | Front porch length, {vertical, horizontal} |
| active_size_i | input | 32 | Active size, {height, width} |
| hs_inv_i | input | 1 | Invert line sync |
| vs_inv_i | input | 1 | Invert frame sync |
| hsync_o | output | 1 | Line sync |
| vsync_o | output | 1 | Frame sync |
| de_o | output | 1 | Data enable |
| x_o | output | 16 | Active column index |
| y_o | output | 16 | Active line index |

## Verification
The block is first driven with a timing set whose phases all have different lengths on both axes. With that set, a swapped half, a misplaced phase boundary or an off-by-one total shows up as a mismatch at a specific clock. A second set is written in the middle of a frame, which shows whether the capture happens at the frame boundary or too early. The polarity inputs are toggled one at a time while frames run, which separates the two inversions. A last set with zero-length porches exercises back-to-back phase transitions and the shortest legal line.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int unsigned FW   = 16;        // field width, half of a config word
  localparam int unsigned WW   = 2 * FW;    // config word width
  localparam int unsigned TW   = FW + 3;    // room for the sum of five fields
  localparam int unsigned AXES = 2;         // 0: horizontal, 1: vertical

  typedef struct packed {
    logic [FW-1:0] ref_len;
    logic [FW-1:0] sync_len;
    logic [FW-1:0] back_len;
    logic [FW-1:0] act_len;
    logic [FW-1:0] front_len;
  } axis_cfg_t;
endpackage

// File: rtl/dtg_counter.sv
module dtg_counter
  import dtg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          step_i,
  input  logic          wrap_i,
  output logic [TW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (clear_i) cnt_o <= '0;
    else if (step_i)  cnt_o <= wrap_i ? '0 : cnt_o + TW'(1);
  end
endmodule

// File: rtl/dtg_axis.sv
module dtg_axis
  import dtg_pkg::*;
(
  input  logic [TW-1:0] cnt_i,
  input  axis_cfg_t     cfg_i,
  output logic          sync_o,
  output logic          act_o,
  output logic          last_o,
  output logic [FW-1:0] pos_o
);
  logic [TW-1:0] sync_beg, sync_end, act_beg, act_end, total;
  logic [TW:0]   cnt_nxt;

  always_comb begin
    sync_beg = TW'(cfg_i.ref_len);
    sync_end = sync_beg + TW'(cfg_i.sync_len);
    act_beg  = sync_end + TW'(cfg_i.back_len);
    act_end  = act_beg + TW'(cfg_i.act_len);
    total    = act_end + TW'(cfg_i.front_len);
    cnt_nxt  = {1'b0, cnt_i} + (TW+1)'(1);
    sync_o   = (cnt_i >= sync_beg) && (cnt_i < sync_end);
    act_o    = (cnt_i >= act_beg) && (cnt_i < act_end);
    last_o   = cnt_nxt >= {1'b0, total};  // a zero total still wraps
    pos_o    = FW'(cnt_i - act_beg);
  end
endmodule

// File: rtl/dtg_timing.sv
module dtg_timing
  import dtg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [WW-1:0] ref_sync_i,
  input  logic [WW-1:0] sync_width_i,
  input  logic [WW-1:0] back_porch_i,
  input  logic [WW-1:0] front_porch_i,
  input  logic [WW-1:0] active_size_i,
  input  logic          hs_inv_i,
  input  logic          vs_inv_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic [FW-1:0] x_o,
  output logic [FW-1:0] y_o
);
  axis_cfg_t [AXES-1:0] cfg_d, cfg_q;
  logic [AXES-1:0]      sync_w, act_w, last_w;
  logic [TW-1:0]        cnt_w [AXES];
  logic [FW-1:0]        pos_w [AXES];
  logic                 run_q, load_w;

  // first idle cycle after reset, or last clock of the frame
  assign load_w = !run_q || (last_w[0] && last_w[1]);

  for (genvar g = 0; g < AXES; g++) begin : g_axis
    assign cfg_d[g].ref_len   = ref_sync_i   [g*FW +: FW];
    assign cfg_d[g].sync_len  = sync_width_i [g*FW +: FW];
    assign cfg_d[g].back_len  = back_porch_i [g*FW +: FW];
    assign cfg_d[g].act_len   = active_size_i[g*FW +: FW];
    assign cfg_d[g].front_len = front_porch_i[g*FW +: FW];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cfg_q[g] <= '0;
      else if (load_w) cfg_q[g] <= cfg_d[g];
    end

    dtg_axis u_axis (
      .cnt_i  (cnt_w[g]),
      .cfg_i  (cfg_q[g]),
      .sync_o (sync_w[g]),
      .act_o  (act_w[g]),
      .last_o (last_w[g]),
      .pos_o  (pos_w[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  dtg_counter u_hcnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (!run_q),
    .step_i  (run_q),
    .wrap_i  (last_w[0]),
    .cnt_o   (cnt_w[0])
  );

  dtg_counter u_vcnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (!run_q),
    .step_i  (run_q && last_w[0]),
    .wrap_i  (last_w[1]),
    .cnt_o   (cnt_w[1])
  );

  assign hsync_o = (run_q && sync_w[0]) ^ hs_inv_i;
  assign vsync_o = (run_q && sync_w[1]) ^ vs_inv_i;
  assign de_o    = run_q && (&act_w);
  assign x_o     = de_o ? pos_w[0] : '0;
  assign y_o     = de_o ? pos_w[1] : '0;
endmodule

// File: rtl/dtg_timing_chk.sv
module dtg_timing_chk
  import dtg_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 run_i,
  input logic                 load_i,
  input logic                 h_last_i,
  input logic [TW-1:0]        h_cnt_i,
  input axis_cfg_t [AXES-1:0] cfg_i,
  input logic                 hs_inv_i,
  input logic                 vs_inv_i,
  input logic                 hsync_i,
  input logic                 vsync_i,
  input logic                 de_i,
  input logic [FW-1:0]        x_i,
  input logic [FW-1:0]        y_i
);
  logic hs_raw, vs_raw;
  assign hs_raw = hsync_i ^ hs_inv_i;
  assign vs_raw = vsync_i ^ vs_inv_i;

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (!de_i && !hs_raw && !vs_raw));

  a_r2_h_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !h_last_i) |=> (h_cnt_i == $past(h_cnt_i) + TW'(1)));

  a_r4_vsync_line_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !h_last_i) |=> $stable(vs_raw));

  a_r5_de_outside_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_i |-> (!hs_raw && !vs_raw));

  a_r6_coord_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_i |-> (x_i == '0 && y_i == '0));

  a_r7_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i) |=> $stable(cfg_i));
endmodule

bind dtg_timing dtg_timing_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .run_i    (run_q),
  .load_i   (load_w),
  .h_last_i (last_w[0]),
  .h_cnt_i  (cnt_w[0]),
  .cfg_i    (cfg_q),
  .hs_inv_i (hs_inv_i),
  .vs_inv_i (vs_inv_i),
  .hsync_i  (hsync_o),
  .vsync_i  (vsync_o),
  .de_i     (de_o),
  .x_i      (x_o),
  .y_i      (y_o)
);

// File: tb/dtg_timing_test.sv
`timescale 1ns/1ps
module dtg_timing_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] w_ref, w_sync, w_back, w_front, w_act;
  logic        hs_inv = 1'b0, vs_inv = 1'b0;
  logic        hsync, vsync, de;
  logic [15:0] x, y;

  int checks = 0, failures = 0;
  bit cmp_en = 1'b0;

  always #2.5 clk = ~clk;

  dtg_timing uut (
    .clk_i(clk), .rst_ni(rst_n),
    .ref_sync_i(w_ref), .sync_width_i(w_sync), .back_porch_i(w_back),
    .front_porch_i(w_front), .active_size_i(w_act),
    .hs_inv_i(hs_inv), .vs_inv_i(vs_inv),
    .hsync_o(hsync), .vsync_o(vsync), .de_o(de), .x_o(x), .y_o(y)
  );

  // reference model: [axis][phase], phase 0 ref 1 sync 2 back 3 active 4 front
  int m_cfg [2][5];
  bit m_run;
  int mh, mv;

  function automatic int half(input logic [31:0] w, input int ax);
    return ax == 0 ? int'(w[15:0]) : int'(w[31:16]);
  endfunction

  task automatic m_load();
    for (int a = 0; a < 2; a++) begin
      m_cfg[a][0] = half(w_ref, a);
      m_cfg[a][1] = half(w_sync, a);
      m_cfg[a][2] = half(w_back, a);
      m_cfg[a][3] = half(w_act, a);
      m_cfg[a][4] = half(w_front, a);
    end
  endtask

  function automatic int tot(input int a);
    return m_cfg[a][0] + m_cfg[a][1] + m_cfg[a][2] + m_cfg[a][3] + m_cfg[a][4];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 1'b0; mh = 0; mv = 0;
    end else if (!m_run) begin
      m_load(); m_run = 1'b1;
    end else if (mh + 1 >= tot(0)) begin
      mh = 0;
      if (mv + 1 >= tot(1)) begin mv = 0; m_load(); end
      else mv++;
    end else mh++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_en && rst_n) begin
    bit e_hs, e_vs, e_de;
    int e_x, e_y, ab_h, ab_v;
    ab_h = m_cfg[0][0] + m_cfg[0][1] + m_cfg[0][2];
    ab_v = m_cfg[1][0] + m_cfg[1][1] + m_cfg[1][2];
    e_hs = m_run && mh >= m_cfg[0][0] && mh < m_cfg[0][0] + m_cfg[0][1];
    e_vs = m_run && mv >= m_cfg[1][0] && mv < m_cfg[1][0] + m_cfg[1][1];
    e_de = m_run && mh >= ab_h && mh < ab_h + m_cfg[0][3]
                 && mv >= ab_v && mv < ab_v + m_cfg[1][3];
    e_x = e_de ? mh - ab_h : 0;
    e_y = e_de ? mv - ab_v : 0;
    chk(hsync === (e_hs ^ hs_inv), "R3 R2 R8 R9 R10 hsync", int'(hsync), int'(e_hs ^ hs_inv));
    chk(vsync === (e_vs ^ vs_inv), "R4 R8 R9 vsync", int'(vsync), int'(e_vs ^ vs_inv));
    chk(de === e_de, "R5 R7 de", int'(de), int'(e_de));
    chk(x === 16'(e_x), "R6 R10 x", int'(x), e_x);
    chk(y === 16'(e_y), "R6 y", int'(y), e_y);
  end

  task automatic set_cfg(input int hr, hs, hb, hw, hf, vr, vs, vb, vh, vf);
    w_ref = {16'(vr), 16'(hr)}; w_sync = {16'(vs), 16'(hs)};
    w_back = {16'(vb), 16'(hb)}; w_act = {16'(vh), 16'(hw)};
    w_front = {16'(vf), 16'(hf)};
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    set_cfg(1, 2, 3, 8, 2, 1, 1, 2, 4, 1);  // 16 x 9
    hs_inv = 1'b1; vs_inv = 1'b0;
    run(3);
    @(negedge clk);
    chk(de === 1'b0 && x === 16'd0 && y === 16'd0, "R1 reset de/xy", int'(de), 0);
    chk(hsync === 1'b1 && vsync === 1'b0, "R1 reset sync levels", int'({hsync, vsync}), 2);
    hs_inv = 1'b0;
    @(negedge clk);
    chk(hsync === 1'b0, "R1 reset sync levels R9", int'(hsync), 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    run(144 * 2 + 50);
    set_cfg(1, 3, 2, 6, 1, 1, 2, 1, 3, 2);   // mid-frame: 13 x 9
    run(144 + 117 * 2);
    hs_inv = 1'b1;
    run(117 + 20);
    vs_inv = 1'b1;
    run(117);
    hs_inv = 1'b0;
    run(60);
    set_cfg(1, 1, 0, 5, 0, 1, 1, 0, 3, 0);   // zero porches: 7 x 5
    run(117 + 35 * 4);
    vs_inv = 1'b0;
    run(35 * 2);
    cmp_en = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule